// File: doc/BRIEF.md
# Interleaved Memory Subnode Sequencer

This block sequences one memory subnode built from four behaviourally modelled DRAM banks on a fixed-timing system bus. A subnode does not decode addresses. It takes a request only when the request's slot and subnode numbers equal the strap inputs `my_slot` and `my_sub`. The row field then picks one 32-byte block, and that block is spread across the banks one word per bank. Bank k holds word k.

The banks are launched one cycle apart after the request cycle. A transfer therefore streams one word per cycle with no nibble-mode parts. The request occupies cycle t0. Five access cycles follow, then four data cycles that carry words 0 to 3 in that fixed order. A write is written into each bank one cycle behind the bus, so it holds the subnode one cycle longer than a read. Words are stored bit for bit, including any check bits, and no checking is done.

An internal interval counter requests refresh. Refresh begins only while no access is running. A request that arrives during refresh, or in the same cycle as a pending refresh, is answered with `retry` and is not taken. The bus has no stall. `rd_valid` and `wr_take` act as the transceiver enables and cannot be back-pressured. The initiator must present write word k in the cycle where `wr_take` is high for it, and must accept read data whenever `rd_valid` is high.

Top module: `msq_subnode_seq`

## Requirements
- R1: After reset, `bank_start`, `bank_ras`, `bank_cas`, `bank_we`, `rd_valid`, `wr_take`, `retry` and `collide` are all low.
- R2: A request is taken only when `req_cmd` is not 2'b00 and both `req_slot`==`my_slot` and `req_sub`==`my_sub`. A request to any other slot or subnode produces no strobe and leaves the stored data unchanged.
- R3: For a request taken in cycle t0, `bank_start[k]` pulses for exactly one cycle, in cycle t0+1+k (k = 0..3). No two start bits are ever high together.
- R4: For a read (`req_cmd` 2'b01), `rd_valid` is high in cycles t0+6 to t0+9. `rd_data` carries word k of the block in cycle t0+6+k.
- R5: For a write (`req_cmd` 2'b10), `wr_take` is high in cycles t0+6 to t0+9, and `bus_wdata` is sampled as word k at the end of cycle t0+6+k. All `WORD_W` bits, check bits included, read back unchanged.
- R6: A read holds the subnode for cycles t0 to t0+9, so a request in t0+10 is taken. A write holds it for t0 to t0+10, so a request in t0+10 collides and one in t0+11 is taken.
- R7: A matching request that arrives while an access is in progress raises `collide` in that cycle and is ignored.
- R8: Every `REF_INTERVAL` cycles a refresh becomes pending. Once the subnode is idle, all `bank_ras` bits go high for `REF_CYCLES` cycles with no start, CAS or write strobe.
- R9: A matching request during an active refresh raises `retry` in that cycle and launches no bank.
- R10: A refresh that is pending in the same cycle as a matching request in idle wins. `retry` is raised and the refresh starts on the next cycle.
- R11: A victim write (`req_cmd` 2'b11) behaves exactly as a write.
- R12: `bank_ras[k]` is high from t0+1+k through that bank's CAS cycle. `bank_cas[k]` is high in t0+6+k for a read and in t0+7+k for a write. `bank_we[k]` is high only in t0+7+k of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_slot | input | SLOT_W | Slot number strap of this subnode |
| my_sub | input | SUB_W | Subnode number strap |
| req_cmd | input | 2 | 00 none, 01 read, 10 write, 11 victim write |
| req_slot | input | SLOT_W | Target slot of the request |
| req_sub | input | SUB_W | Target subnode of the request |
| req_row | input | ROW_W | Block index within the banks |
| bus_wdata | input | WORD_W | Write word from the bus |
| wr_take | output | 1 | Receive enable; bus_wdata is sampled this cycle |
| rd_valid | output | 1 | Drive enable; rd_data is valid this cycle |
| rd_data | output | WORD_W | Read word to the bus |
| bank_start | output | NBANK | Per-bank access launch pulse |
| bank_ras | output | NBANK | Per-bank row strobe |
| bank_cas | output | NBANK | Per-bank column strobe |
| bank_we | output | NBANK | Per-bank write strobe |
| retry | output | 1 | Request refused because of refresh |
| collide | output | 1 | Request arrived while an access was busy |

## Verification
The functions that can fall in the same cycle are a refresh falling due and a matching request arriving while the subnode is idle. The bench counts bus edges from reset, so it knows the exact cycle in which refresh becomes pending, and it places a read request in that cycle. The outcome is judged at the ports. `retry` must be high and `collide` low in that cycle. In the following cycles every RAS bit must be high while no start pulse appears. A second request is then placed during the active refresh, and a third just after the refresh ends, which must be taken normally.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_READ   = 2'b01,
    CMD_WRITE  = 2'b10,
    CMD_VICTIM = 2'b11
  } cmd_e;
endpackage

// File: rtl/msq_match.sv
module msq_match #(
  parameter int SLOT_W = 4,
  parameter int SUB_W  = 3
) (
  input  logic [1:0]        cmd,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SUB_W-1:0]  sub,
  input  logic [SLOT_W-1:0] my_slot,
  input  logic [SUB_W-1:0]  my_sub,
  output logic              hit,
  output logic              is_wr
);
  import msq_pkg::*;

  // geographic select: compare strap numbers only, no address decode
  assign hit   = (cmd_e'(cmd) != CMD_NONE) && (slot == my_slot) && (sub == my_sub);
  assign is_wr = (cmd_e'(cmd) == CMD_WRITE) || (cmd_e'(cmd) == CMD_VICTIM);
endmodule

// File: rtl/msq_refresh.sv
module msq_refresh #(
  parameter int INTERVAL = 256,
  parameter int CYCLES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic access_busy,
  output logic pend,
  output logic active
);
  localparam int IVL_W = $clog2(INTERVAL);
  localparam int RC_W  = $clog2(CYCLES + 1);
  localparam logic [IVL_W-1:0] IVL_LAST = IVL_W'(INTERVAL - 1);

  logic [IVL_W-1:0] ivl;
  logic [RC_W-1:0]  rc;
  logic             start;

  assign active = (rc != '0);
  assign start  = pend && !access_busy && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl  <= '0;
      pend <= 1'b0;
      rc   <= '0;
    end else begin
      ivl <= (ivl == IVL_LAST) ? '0 : ivl + 1'b1;
      if (ivl == IVL_LAST)
        pend <= 1'b1;
      else if (start)
        pend <= 1'b0;
      if (start)
        rc <= RC_W'(CYCLES);
      else if (active)
        rc <= rc - 1'b1;
    end
  end
endmodule

// File: rtl/msq_bank.sv
module msq_bank #(
  parameter int ROW_W  = 4,
  parameter int WORD_W = 72
) (
  input  logic              clk,
  input  logic              cap,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] hold;

  // word captured from the bus, written one cycle later
  always_ff @(posedge clk) begin
    if (cap)
      hold <= wdata;
    if (we)
      mem[row] <= hold;
  end

  assign rdata = mem[row];
endmodule

// File: rtl/msq_subnode_seq.sv
module msq_subnode_seq #(
  parameter int SLOT_W       = 4,
  parameter int SUB_W        = 3,
  parameter int ROW_W        = 4,
  parameter int WORD_W       = 72,
  parameter int NBANK        = 4,
  parameter int ACCESS_CYC   = 5,
  parameter int REF_INTERVAL = 256,
  parameter int REF_CYCLES   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] my_slot,
  input  logic [SUB_W-1:0]  my_sub,
  input  logic [1:0]        req_cmd,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              wr_take,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [NBANK-1:0]  bank_start,
  output logic [NBANK-1:0]  bank_ras,
  output logic [NBANK-1:0]  bank_cas,
  output logic [NBANK-1:0]  bank_we,
  output logic              retry,
  output logic              collide
);
  localparam int DATA0   = ACCESS_CYC + 1;
  localparam int LAST_RD = ACCESS_CYC + NBANK;
  localparam int LAST_WR = LAST_RD + 1;
  localparam int CNT_W   = $clog2(LAST_WR + 1);
  localparam logic [CNT_W-1:0] P_DATA0 = CNT_W'(DATA0);
  localparam logic [CNT_W-1:0] P_LRD   = CNT_W'(LAST_RD);
  localparam logic [CNT_W-1:0] P_LWR   = CNT_W'(LAST_WR);

  logic             hit, is_wr;
  logic             busy, acc_fire;
  logic             ref_pend, ref_active;
  logic [CNT_W-1:0] phase;
  logic             op_wr;
  logic [ROW_W-1:0] row_q;
  logic             in_data;
  logic [WORD_W-1:0] bank_rd [NBANK];
  logic [WORD_W-1:0] rd_sel;
  logic [NBANK-1:0]  bank_cap;

  msq_match #(.SLOT_W(SLOT_W), .SUB_W(SUB_W)) u_match (
    .cmd     (req_cmd),
    .slot    (req_slot),
    .sub     (req_sub),
    .my_slot (my_slot),
    .my_sub  (my_sub),
    .hit     (hit),
    .is_wr   (is_wr)
  );

  msq_refresh #(.INTERVAL(REF_INTERVAL), .CYCLES(REF_CYCLES)) u_ref (
    .clk         (clk),
    .rst_n       (rst_n),
    .access_busy (busy),
    .pend        (ref_pend),
    .active      (ref_active)
  );

  assign busy     = (phase != '0);
  assign collide  = hit && busy;
  assign retry    = hit && !busy && (ref_active || ref_pend);
  assign acc_fire = hit && !busy && !ref_active && !ref_pend;

  // phase 0 = idle; phase p = cycle t0+p of the running access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      op_wr <= 1'b0;
      row_q <= '0;
    end else if (acc_fire) begin
      phase <= CNT_W'(1);
      op_wr <= is_wr;
      row_q <= req_row;
    end else if (busy) begin
      phase <= (phase == (op_wr ? P_LWR : P_LRD)) ? '0 : phase + 1'b1;
    end
  end

  assign in_data  = busy && (phase >= P_DATA0) && (phase <= P_LRD);
  assign rd_valid = in_data && !op_wr;
  assign wr_take  = in_data && op_wr;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    localparam logic [CNT_W-1:0] P_START = CNT_W'(k + 1);
    localparam logic [CNT_W-1:0] P_RCAS  = CNT_W'(DATA0 + k);
    localparam logic [CNT_W-1:0] P_WCAS  = CNT_W'(DATA0 + k + 1);

    logic [CNT_W-1:0] cas_at;
    assign cas_at = op_wr ? P_WCAS : P_RCAS;

    assign bank_start[k] = busy && (phase == P_START);
    assign bank_ras[k]   = (busy && (phase >= P_START) && (phase <= cas_at)) || ref_active;
    assign bank_cas[k]   = busy && (phase == cas_at);
    assign bank_we[k]    = busy && op_wr && (phase == P_WCAS);
    assign bank_cap[k]   = busy && op_wr && (phase == P_RCAS);

    msq_bank #(.ROW_W(ROW_W), .WORD_W(WORD_W)) u_bank (
      .clk   (clk),
      .cap   (bank_cap[k]),
      .we    (bank_we[k]),
      .row   (row_q),
      .wdata (bus_wdata),
      .rdata (bank_rd[k])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NBANK; k++)
      if (phase == CNT_W'(DATA0 + k))
        rd_sel = bank_rd[k];
  end

  assign rd_data = rd_valid ? rd_sel : '0;
endmodule

// File: rtl/msq_subnode_seq_chk.sv
module msq_subnode_seq_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] bank_start,
  input logic [NBANK-1:0] bank_ras,
  input logic [NBANK-1:0] bank_cas,
  input logic [NBANK-1:0] bank_we,
  input logic             rd_valid,
  input logic             wr_take,
  input logic             retry,
  input logic             collide,
  input logic             acc_fire
);
  // R3: never two launches in one cycle
  a_r3_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_start));

  // R3: launches walk across the banks one cycle apart
  for (genvar k = 0; k < NBANK - 1; k++) begin : g_chain
    a_r3_start_chain: assert property (@(posedge clk) disable iff (!rst_n)
      bank_start[k] |=> bank_start[k+1]);
  end

  // R2: bank 0 launches only in the cycle after a request was taken
  a_r2_launch_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    bank_start[0] |-> $past(acc_fire));

  // R9: a refused request launches nothing
  a_r9_retry_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> (bank_start == '0));

  // R7: a colliding request does not restart the sequence
  a_r7_collide_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> !bank_start[0]);

  // R4: the read burst does not stop after its first word
  a_r4_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |=> rd_valid);

  // R5: the bus is never driven and received in the same cycle
  a_r5_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_take));

  // R12: first bank write trails the first received word by one cycle
  a_r12_we_trails_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_take) |=> bank_we[0]);

  // R12: a write strobe only occurs together with that bank's CAS and RAS
  a_r12_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_we & ~(bank_cas & bank_ras)) == '0));
endmodule

bind msq_subnode_seq msq_subnode_seq_chk #(.NBANK(NBANK)) u_chk (.*);

// File: tb/tb_msq_subnode_seq.sv
module tb_msq_subnode_seq;
  localparam int PERIOD = 10;
  localparam int W      = 72;
  localparam int RW     = 4;
  localparam int IVL    = 100;
  localparam int RC     = 4;
  localparam logic [3:0] MY_SLOT = 4'd5;
  localparam logic [2:0] MY_SUB  = 3'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    req_cmd = 2'b00;
  logic [3:0]    req_slot = MY_SLOT;
  logic [2:0]    req_sub = MY_SUB;
  logic [RW-1:0] req_row = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic          wr_take, rd_valid, retry, collide;
  logic [W-1:0]  rd_data;
  logic [3:0]    bank_start, bank_ras, bank_cas, bank_we;

  int n_chk = 0;
  int n_bad = 0;
  int ecount = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk)
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;

  msq_subnode_seq #(
    .ROW_W(RW), .WORD_W(W), .REF_INTERVAL(IVL), .REF_CYCLES(RC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .my_slot(MY_SLOT), .my_sub(MY_SUB),
    .req_cmd(req_cmd), .req_slot(req_slot), .req_sub(req_sub), .req_row(req_row),
    .bus_wdata(bus_wdata), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .bank_start(bank_start), .bank_ras(bank_ras), .bank_cas(bank_cas),
    .bank_we(bank_we), .retry(retry), .collide(collide)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at edge %0d", tag, act, exp, ecount);
    end
  endtask

  // wait so that an operation of span cycles starting next cycle avoids refresh
  task automatic wait_safe(input int span);
    forever begin
      int s;
      s = (ecount + 1) % IVL;
      if (s > RC + 1 && s + span < IVL) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic wait_to(input int t);
    while (ecount < t) begin
      @(posedge clk); #1;
    end
  endtask

  // one full access; checks strobes and enables cycle by cycle
  task automatic run_op(input logic [1:0] cmd, input logic [RW-1:0] row,
                        input logic [4*W-1:0] wpk, output logic [4*W-1:0] rpk,
                        input string tag);
    bit wr;
    int last;
    wr = cmd[1];
    last = wr ? 10 : 9;
    rpk = '0;
    wait_safe(12);
    @(posedge clk); #1;
    req_cmd = cmd; req_slot = MY_SLOT; req_sub = MY_SUB; req_row = row;
    for (int c = 0; c <= last; c++) begin
      logic [3:0] e_st, e_cas, e_we, e_ras;
      if (c > 0) begin @(posedge clk); #1; end
      if (c == 1) req_cmd = 2'b00;
      if (wr && c >= 6 && c <= 9) bus_wdata = wpk[(c-6)*W +: W];
      @(negedge clk);
      if (c == 0) chk(!retry && !collide, {tag, " R2 taken without retry/collide"},
                      {retry, collide}, 0);
      e_st  = (c >= 1 && c <= 4) ? 4'(1 << (c-1)) : 4'd0;
      e_cas = wr ? ((c >= 7 && c <= 10) ? 4'(1 << (c-7)) : 4'd0)
                 : ((c >= 6 && c <= 9)  ? 4'(1 << (c-6)) : 4'd0);
      e_we  = wr ? e_cas : 4'd0;
      e_ras = 4'd0;
      for (int k = 0; k < 4; k++)
        if (c >= k + 1 && c <= (wr ? 7 + k : 6 + k)) e_ras[k] = 1'b1;
      chk(bank_start == e_st, {tag, " R3 bank_start"}, bank_start, e_st);
      chk(bank_cas == e_cas && bank_we == e_we && bank_ras == e_ras,
          {tag, " R12 ras/cas/we"}, {bank_ras, bank_cas, bank_we}, {e_ras, e_cas, e_we});
      chk(rd_valid == (!wr && c >= 6 && c <= 9), {tag, " R4 rd_valid"}, rd_valid,
          (!wr && c >= 6 && c <= 9));
      chk(wr_take == (wr && c >= 6 && c <= 9), {tag, " R5 wr_take"}, wr_take,
          (wr && c >= 6 && c <= 9));
      if (!wr && c >= 6 && c <= 9) rpk[(c-6)*W +: W] = rd_data;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(bank_start == 0 && bank_ras == 0 && bank_cas == 0 && bank_we == 0,
        "R1 strobes after reset", {bank_start, bank_ras, bank_cas, bank_we}, 0);
    chk(!rd_valid && !wr_take && !retry && !collide, "R1 enables after reset",
        {rd_valid, wr_take, retry, collide}, 0);
  endtask

  task automatic t_write_read(input logic [1:0] cmd, input logic [RW-1:0] row,
                              input logic [4*W-1:0] pk, input string tag);
    logic [4*W-1:0] rb;
    run_op(cmd, row, pk, rb, {tag, " wr"});
    run_op(2'b01, row, '0, rb, {tag, " rd"});
    for (int k = 0; k < 4; k++)
      chk(rb[k*W +: W] === pk[k*W +: W], {tag, " R5 word order and all bits"},
          rb[k*W +: W], pk[k*W +: W]);
  endtask

  task automatic t_mismatch;
    logic [4*W-1:0] pk, rb;
    pk = {72'hA1_0000_0000_0000_0001, 72'hA2_0000_0000_0000_0002,
          72'hA3_0000_0000_0000_0003, 72'hA4_0000_0000_0000_0004};
    run_op(2'b10, 4'd7, pk, rb, "mm setup");
    wait_safe(14);
    for (int v = 0; v < 2; v++) begin
      @(posedge clk); #1;
      req_cmd = 2'b10; req_row = 4'd7;
      req_slot = (v == 0) ? 4'd6 : MY_SLOT;
      req_sub  = (v == 0) ? MY_SUB : 3'd2;
      for (int c = 0; c < 12; c++) begin
        if (c > 0) begin @(posedge clk); #1; req_cmd = 2'b00; end
        bus_wdata = '1;
        @(negedge clk);
        chk(bank_start == 0 && !wr_take && !collide && !retry,
            "R2 foreign request ignored", {bank_start, wr_take, collide, retry}, 0);
      end
    end
    req_slot = MY_SLOT; req_sub = MY_SUB;
    run_op(2'b01, 4'd7, '0, rb, "mm rd");
    chk(rb === pk, "R2 data untouched by foreign write", rb[W-1:0], pk[W-1:0]);
  endtask

  // issue op at cycle 0 and extra requests at given cycles, judge collide/take
  task automatic t_occupancy(input logic [1:0] cmd, input int col_c, input int ok_c,
                             input string tag);
    wait_safe(ok_c + 14);
    @(posedge clk); #1;
    req_cmd = cmd; req_row = 4'd1; req_slot = MY_SLOT; req_sub = MY_SUB;
    for (int c = 1; c <= ok_c + 1; c++) begin
      @(posedge clk); #1;
      req_cmd = (c == 5 || c == col_c || c == ok_c) ? 2'b01 : 2'b00;
      @(negedge clk);
      if (c == 5 || c == col_c)
        chk(collide && !retry, {tag, " R7 collide while busy"}, {collide, retry}, 2'b10);
      if (c == 6 || c == col_c + 1)
        chk(bank_start == 0, {tag, " R7 collided request ignored"}, bank_start, 0);
      if (c == ok_c)
        chk(!collide && !retry, {tag, " R6 request at end of occupancy"},
            {collide, retry}, 0);
      if (c == ok_c + 1)
        chk(bank_start == 4'b0001, {tag, " R6 request taken"}, bank_start, 1);
    end
    req_cmd = 2'b00;
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic t_refresh;
    int t;
    logic [4*W-1:0] rb;
    t = (ecount / IVL + 1) * IVL;
    wait_to(t);
    req_cmd = 2'b01; req_row = 4'd3; req_slot = MY_SLOT; req_sub = MY_SUB;
    @(negedge clk);
    chk(retry && !collide, "R10 pending refresh wins same cycle", {retry, collide}, 2'b10);
    for (int c = 1; c <= RC + 1; c++) begin
      @(posedge clk); #1;
      req_cmd = (c == 2) ? 2'b01 : 2'b00;
      @(negedge clk);
      if (c == 2) chk(retry, "R9 retry during refresh", retry, 1);
      if (c <= RC) begin
        chk(bank_ras == 4'hF && bank_cas == 0 && bank_we == 0,
            "R8 refresh RAS on all banks", {bank_ras, bank_cas, bank_we}, 12'hF00);
        chk(bank_start == 0, "R10 no launch during refresh", bank_start, 0);
      end else begin
        chk(bank_ras == 0, "R8 refresh lasts REF_CYCLES", bank_ras, 0);
      end
    end
    run_op(2'b01, 4'd3, '0, rb, "after refresh R9");
    chk(rb[W-1:0] === 72'h5A_0123_4567_89AB_CDEF, "R9 data intact after refresh",
        rb[W-1:0], 72'h5A_0123_4567_89AB_CDEF);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    t_reset();
    t_write_read(2'b10, 4'd3,
      {72'h11_1111_2222_3333_4444, 72'h22_5555_6666_7777_8888,
       72'h33_9999_AAAA_BBBB_CCCC, 72'h5A_0123_4567_89AB_CDEF}, "pattern A");
    t_write_read(2'b10, 4'd15, {4{72'hFF_FFFF_FFFF_FFFF_FFFF}}, "all ones");
    t_write_read(2'b11, 4'd0,
      {72'hAA_AAAA_AAAA_AAAA_AAAA, 72'h55_5555_5555_5555_5555,
       72'h80_0000_0000_0000_0001, 72'h01_8000_0000_0000_0000}, "R11 victim");
    t_mismatch();
    t_occupancy(2'b01, 9, 10, "read");
    t_occupancy(2'b10, 10, 11, "write");
    t_refresh();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule